// File: doc/BRIEF.md
# Deferred Hidden Surface Removal Unit

This block resolves visibility for one screen tile before any shading work is requested. Rasterised coverage arrives one sample at a time, in submission order. Each sample carries its tile position, sample index, depth, a primitive identifier and a flag that marks the primitive as opaque or transparent. The block keeps a depth store and an owner-tag store for every sample slot of the tile. Opaque samples that pass the depth test only update these stores. No shading request is raised for them until the tile is complete. As a result, only the surfaces that end up visible are shaded.

Transparent geometry has to be blended over whatever is visible beneath it. When a new transparent primitive arrives, the block first drains every pending visible tag to the shading output. It then passes the transparent primitive's surviving samples straight through, without recording their depth. A tile-end strobe drains the remaining tags and is followed by a completion pulse. A tile-start strobe resets the stores. The shading output is a valid/ready stream of (x, y, sample, primitive) records.

Top module: `hsr_tile_unit`

## Requirements
- R1: After reset, and after a tile-start strobe accepted while `in_ready` is high, every depth slot holds the far value (all ones) and no slot has an owner tag. A tile that then receives only a tile-end strobe produces no records.
- R2: A sample passes only when its depth is strictly less than the stored depth. A sample of equal or greater depth changes nothing.
- R3: A passing opaque sample writes its depth into the slot and makes its primitive the owner of that slot, replacing any earlier owner.
- R4: Opaque samples never produce a record on their own. Their records appear only in a drain caused by a transparent primitive or by tile end.
- R5: The first sample of a new transparent primitive starts a drain if any slot is owned. A primitive is new when the previous accepted sample was opaque or had a different identifier. The drain emits one record per owned slot, in increasing address order, where address = {y, x, sample}. All of these records come before any record of that transparent primitive.
- R6: A passing transparent sample is emitted at once, in arrival order, and leaves the stored depth unchanged.
- R7: A drain clears every tag it emits, so that slot is not emitted again. The stored depths are kept, so later samples are still tested against them.
- R8: An opaque sample that passes over a slot last written by a transparent primitive causes no extra drain and no record.
- R9: A tile-end strobe drains all remaining owned slots. `tile_done` then pulses for exactly one cycle, after the last record has been accepted downstream.
- R10: While `out_valid` is high and `out_ready` is low, the output record stays unchanged.
- R11: `in_ready` is low while the stores are being cleared and while a drain is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tile_start | input | 1 | Clear stores for a new tile (taken when in_ready) |
| tile_end | input | 1 | Final drain and completion (taken when in_ready) |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample or strobe accepted this cycle |
| in_x | input | XW | Sample column in tile |
| in_y | input | YW | Sample row in tile |
| in_s | input | SW | Sample index within pixel |
| in_z | input | DEPTH_W | Sample depth, smaller is closer |
| in_prim | input | PRIM_W | Primitive identifier |
| in_transp | input | 1 | Primitive is transparent |
| out_valid | output | 1 | Shading record present |
| out_ready | input | 1 | Downstream accepts the record |
| out_x | output | XW | Record column |
| out_y | output | YW | Record row |
| out_s | output | SW | Record sample index |
| out_prim | output | PRIM_W | Record primitive identifier |
| tile_done | output | 1 | One-cycle tile completion pulse |

## Verification
A stale depth slot or a missed tag shows up at the next drain. It appears as a missing, extra or wrongly owned record, or as a record for a sample that should have been hidden. A tag that is not cleared after a drain shows up again at tile end as a duplicate record. A depth write made by a transparent sample shows up as a later opaque sample being rejected when it should have passed. The bench keeps its own model of the depth and owner stores. It queues each expected record as the stimulus is sent, and compares every accepted record in order under irregular backpressure. A wrong order or wrong ownership is therefore reported at the first record that differs.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_IDLE,
    ST_TEST,
    ST_FLUSH,
    ST_END
  } hsr_state_e;
endpackage

// File: rtl/hsr_ram.sv
module hsr_ram #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hsr_out_reg.sv
module hsr_out_reg #(
  parameter int DW = 19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic          free,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] dout
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dout      <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      dout      <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(dout)));
  // R10
  load_free_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> free);
endmodule

// File: rtl/hsr_tile_unit.sv
module hsr_tile_unit
  import hsr_pkg::*;
#(
  parameter int TILE_W  = 32,
  parameter int TILE_H  = 32,
  parameter int SAMPLES = 2,
  parameter int DEPTH_W = 16,
  parameter int PRIM_W  = 8,
  localparam int XW  = $clog2(TILE_W),
  localparam int YW  = $clog2(TILE_H),
  localparam int SBW = $clog2(SAMPLES),
  localparam int SW  = (SBW > 0) ? SBW : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tile_start,
  input  logic               tile_end,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [XW-1:0]      in_x,
  input  logic [YW-1:0]      in_y,
  input  logic [SW-1:0]      in_s,
  input  logic [DEPTH_W-1:0] in_z,
  input  logic [PRIM_W-1:0]  in_prim,
  input  logic               in_transp,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [XW-1:0]      out_x,
  output logic [YW-1:0]      out_y,
  output logic [SW-1:0]      out_s,
  output logic [PRIM_W-1:0]  out_prim,
  output logic               tile_done
);
  localparam int AW = XW + YW + SBW;
  localparam int TW = PRIM_W + 1;
  localparam int RW = XW + YW + SW + PRIM_W;

  hsr_state_e state;
  logic [AW-1:0] walk, rd_addr, wr_addr, in_addr, smp_addr;
  logic [XW-1:0] walk_x, smp_x;
  logic [YW-1:0] walk_y, smp_y;
  logic [SW-1:0] walk_s, smp_s;
  logic [DEPTH_W-1:0] smp_z, z_rd, z_wd;
  logic [PRIM_W-1:0]  smp_prim, tp_id;
  logic [TW-1:0] t_rd, t_wd;
  logic smp_transp, dirty, tp_act, ret_test;
  logic z_we, t_we, ld, ob_free, walk_last, z_pass, tp_new, go_flush_tp, flush_step;
  logic [RW-1:0] ld_data, ob_q;

  generate
    if (SBW > 0) begin : g_multi
      assign in_addr  = {in_y, in_x, in_s};
      assign smp_addr = {smp_y, smp_x, smp_s};
      assign walk_s   = walk[SBW-1:0];
      assign walk_x   = walk[SBW +: XW];
      assign walk_y   = walk[SBW+XW +: YW];
    end else begin : g_single
      assign in_addr  = {in_y, in_x};
      assign smp_addr = {smp_y, smp_x};
      assign walk_s   = '0;
      assign walk_x   = walk[0 +: XW];
      assign walk_y   = walk[XW +: YW];
    end
  endgenerate

  hsr_ram #(.AW(AW), .DW(DEPTH_W)) depth_ram_i (
    .clk(clk), .we(z_we), .waddr(wr_addr), .wdata(z_wd), .raddr(rd_addr), .rdata(z_rd));
  hsr_ram #(.AW(AW), .DW(TW)) tag_ram_i (
    .clk(clk), .we(t_we), .waddr(wr_addr), .wdata(t_wd), .raddr(rd_addr), .rdata(t_rd));
  hsr_out_reg #(.DW(RW)) out_reg_i (
    .clk(clk), .rst(rst), .load(ld), .din(ld_data), .free(ob_free),
    .out_valid(out_valid), .out_ready(out_ready), .dout(ob_q));

  assign out_prim = ob_q[PRIM_W-1:0];
  assign out_s    = ob_q[PRIM_W +: SW];
  assign out_y    = ob_q[PRIM_W+SW +: YW];
  assign out_x    = ob_q[PRIM_W+SW+YW +: XW];

  assign in_ready    = (state == ST_IDLE);
  assign walk_last   = &walk;
  assign z_pass      = smp_z < z_rd;
  assign tp_new      = in_transp && !(tp_act && in_prim == tp_id);
  assign go_flush_tp = tp_new && dirty;
  assign flush_step  = !t_rd[PRIM_W] || ob_free;

  always_comb begin
    rd_addr = walk;
    wr_addr = walk;
    z_we    = 1'b0;
    t_we    = 1'b0;
    z_wd    = '1;
    t_wd    = '0;
    ld      = 1'b0;
    ld_data = '0;
    case (state)
      ST_CLEAR: begin
        z_we = 1'b1;
        t_we = 1'b1;
      end
      ST_IDLE: begin
        if (!tile_start && !tile_end && in_valid && !go_flush_tp) rd_addr = in_addr;
        else rd_addr = '0;
      end
      ST_TEST: begin
        rd_addr = smp_addr;
        wr_addr = smp_addr;
        if (!smp_transp && z_pass) begin
          z_we = 1'b1;
          t_we = 1'b1;
          z_wd = smp_z;
          t_wd = {1'b1, smp_prim};
        end
        if (smp_transp && z_pass && ob_free) begin
          ld      = 1'b1;
          ld_data = {smp_x, smp_y, smp_s, smp_prim};
        end
      end
      ST_FLUSH: begin
        if (t_rd[PRIM_W] && ob_free) begin
          ld      = 1'b1;
          t_we    = 1'b1;
          ld_data = {walk_x, walk_y, walk_s, t_rd[PRIM_W-1:0]};
        end
        if (flush_step) rd_addr = walk_last ? smp_addr : walk + AW'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_CLEAR;
      walk       <= '0;
      dirty      <= 1'b0;
      tp_act     <= 1'b0;
      tp_id      <= '0;
      ret_test   <= 1'b0;
      tile_done  <= 1'b0;
      smp_x      <= '0;
      smp_y      <= '0;
      smp_s      <= '0;
      smp_z      <= '0;
      smp_prim   <= '0;
      smp_transp <= 1'b0;
    end else begin
      tile_done <= 1'b0;
      case (state)
        ST_CLEAR: begin
          walk   <= walk + AW'(1);
          dirty  <= 1'b0;
          tp_act <= 1'b0;
          if (walk_last) state <= ST_IDLE;
        end
        ST_IDLE: begin
          walk <= '0;
          if (tile_start) begin
            state <= ST_CLEAR;
          end else if (tile_end) begin
            ret_test <= 1'b0;
            state    <= dirty ? ST_FLUSH : ST_END;
          end else if (in_valid) begin
            smp_x      <= in_x;
            smp_y      <= in_y;
            smp_s      <= in_s;
            smp_z      <= in_z;
            smp_prim   <= in_prim;
            smp_transp <= in_transp;
            tp_act     <= in_transp;
            if (in_transp) tp_id <= in_prim;
            ret_test   <= 1'b1;
            state      <= go_flush_tp ? ST_FLUSH : ST_TEST;
          end
        end
        ST_TEST: begin
          if (smp_transp) begin
            if (!z_pass || ob_free) state <= ST_IDLE;
          end else begin
            if (z_pass) dirty <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_FLUSH: begin
          if (flush_step) begin
            walk <= walk + AW'(1);
            if (walk_last) begin
              dirty <= 1'b0;
              state <= ret_test ? ST_TEST : ST_END;
            end
          end
        end
        ST_END: begin
          if (!out_valid) begin
            tile_done <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  clear_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CLEAR && walk_last) |=> (state == ST_IDLE));
  // R5
  walk_order_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FLUSH && $past(state == ST_FLUSH))
      |-> (walk == $past(walk) || walk == $past(walk) + AW'(1)));
  // R6
  transp_no_depth_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TEST && smp_transp) |-> !z_we);
  // R9
  done_drained_chk: assert property (@(posedge clk) disable iff (rst)
    tile_done |-> !out_valid);
  // R11
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FLUSH || state == ST_CLEAR) |-> !in_ready);
endmodule

// File: tb/hsr_tile_unit_tb_top.sv
module hsr_tile_unit_tb_top;
  localparam int N = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tile_start = 1'b0, tile_end = 1'b0, in_valid = 1'b0, in_transp = 1'b0;
  logic in_ready, out_valid, tile_done;
  logic out_ready = 1'b1;
  logic [4:0] in_x = '0, in_y = '0, out_x, out_y;
  logic [0:0] in_s = '0, out_s;
  logic [15:0] in_z = '0;
  logic [7:0] in_prim = '0, out_prim;

  int checks = 0, errors = 0, cyc = 0;
  int zb[N];
  bit tv[N];
  int tpr[N];
  bit m_dirty, m_tpact;
  int m_tpid;
  int eq_addr[$];
  int eq_prim[$];
  string eq_req[$];

  always #2 clk = ~clk;

  hsr_tile_unit dut_i (
    .clk(clk), .rst(rst), .tile_start(tile_start), .tile_end(tile_end),
    .in_valid(in_valid), .in_ready(in_ready), .in_x(in_x), .in_y(in_y), .in_s(in_s),
    .in_z(in_z), .in_prim(in_prim), .in_transp(in_transp),
    .out_valid(out_valid), .out_ready(out_ready), .out_x(out_x), .out_y(out_y),
    .out_s(out_s), .out_prim(out_prim), .tile_done(tile_done));

  function automatic int adr(int x, int y, int s);
    return y * 64 + x * 2 + s;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // backpressure pattern, driven away from the sampling edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready = ((cyc % 7) != 3) && ((cyc % 97) > 12);
  end

  // scoreboard monitor
  logic stall_prev = 1'b0;
  int prev_word = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (stall_prev)
        check(out_valid && {out_x, out_y, out_s, out_prim} == prev_word[18:0], "R10",
              "held record", {out_x, out_y, out_s, out_prim}, prev_word);
      stall_prev = out_valid && !out_ready;
      prev_word = {13'd0, out_x, out_y, out_s, out_prim};
      if (out_valid && out_ready) begin
        if (eq_addr.size() == 0) begin
          check(1'b0, "R4", "unexpected record addr", adr(out_x, out_y, out_s), -1);
        end else begin
          automatic int ea = eq_addr.pop_front();
          automatic int ep = eq_prim.pop_front();
          automatic string rq = eq_req.pop_front();
          check(adr(out_x, out_y, out_s) == ea, rq, "record addr", adr(out_x, out_y, out_s), ea);
          check(int'(out_prim) == ep, rq, "record prim", out_prim, ep);
        end
      end
    end
  end

  task automatic model_drain(string req);
    for (int a = 0; a < N; a++) begin
      if (tv[a]) begin
        eq_addr.push_back(a);
        eq_prim.push_back(tpr[a]);
        eq_req.push_back(req);
        tv[a] = 1'b0;
      end
    end
    m_dirty = 1'b0;
  endtask

  task automatic send(int x, int y, int s, int z, int prim, bit tr);
    automatic int a = adr(x, y, s);
    if (tr) begin
      if (!(m_tpact && prim == m_tpid) && m_dirty) model_drain("R5");
      m_tpact = 1'b1;
      m_tpid = prim;
      if (z < zb[a]) begin
        eq_addr.push_back(a);
        eq_prim.push_back(prim);
        eq_req.push_back("R6");
      end
    end else begin
      m_tpact = 1'b0;
      if (z < zb[a]) begin
        zb[a] = z;
        tv[a] = 1'b1;
        tpr[a] = prim;
        m_dirty = 1'b1;
      end
    end
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_x = 5'(x); in_y = 5'(y); in_s = 1'(s);
    in_z = 16'(z); in_prim = 8'(prim); in_transp = tr;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic start_tile();
    for (int a = 0; a < N; a++) begin
      zb[a] = 65535;
      tv[a] = 1'b0;
    end
    m_dirty = 1'b0;
    m_tpact = 1'b0;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    tile_start = 1'b1;
    @(negedge clk);
    tile_start = 1'b0;
    check(!in_ready, "R11", "in_ready during clear", in_ready, 0);
    while (!in_ready) @(negedge clk);
  endtask

  task automatic end_tile(bit expect_drain);
    int busy;
    model_drain("R9");
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    tile_end = 1'b1;
    @(negedge clk);
    tile_end = 1'b0;
    busy = 0;
    while (!tile_done) begin
      if (in_ready) busy = -1;
      else if (busy >= 0) busy++;
      @(negedge clk);
    end
    if (expect_drain)
      check(busy > 2000, "R11", "busy cycles before done", busy, 2048);
    check(eq_addr.size() == 0, "R9", "records left at done", eq_addr.size(), 0);
    @(negedge clk);
    check(!tile_done, "R9", "done pulse width", tile_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!in_ready, "R11", "in_ready after reset", in_ready, 0);
    check(!out_valid, "R1", "out_valid after reset", out_valid, 0);

    // R1: empty tile yields nothing
    start_tile();
    end_tile(1'b0);

    // R2 R3 R4 R7: opaque only
    start_tile();
    send(0, 0, 0, 100, 1, 0);
    send(1, 0, 0, 100, 1, 0);
    send(5, 3, 1, 100, 1, 0);
    send(0, 0, 0, 50, 2, 0);   // R3 closer replaces owner
    send(1, 0, 0, 100, 2, 0);  // R2 equal depth rejected
    send(5, 3, 1, 200, 2, 0);  // R2 farther rejected
    send(31, 31, 1, 10, 3, 0); // last slot
    repeat (4) @(negedge clk);
    check(!out_valid, "R4", "no record for opaque", out_valid, 0);
    end_tile(1'b1);

    // R5 R6 R7 R8: transparent handling
    start_tile();
    send(2, 2, 0, 80, 4, 0);
    send(3, 2, 0, 80, 4, 0);
    send(2, 2, 0, 60, 5, 1);   // R5 drain then R6 emit
    send(3, 2, 0, 90, 5, 1);   // fails
    send(4, 2, 0, 10, 5, 1);   // R6 emit
    send(6, 2, 0, 30, 5, 1);   // same primitive, no drain
    send(2, 2, 0, 70, 6, 0);   // R6 depth untouched by transparent
    send(3, 2, 0, 85, 6, 0);   // R7 depth kept after drain
    send(10, 10, 1, 5, 7, 1);  // R5 drain of prim 6
    send(10, 10, 1, 1, 8, 0);  // R8 opaque over transparent
    repeat (4) @(negedge clk);
    check(eq_addr.size() == 0, "R8", "pending records before tile end", eq_addr.size(), 0);
    end_tile(1'b1);

    // R7: drained tags are not emitted again at tile end
    start_tile();
    send(7, 1, 1, 40, 9, 0);
    send(8, 1, 0, 40, 10, 1);
    send(7, 1, 1, 45, 11, 0);
    end_tile(1'b0);

    summary();
    $finish;
  end
endmodule